// File: doc/BRIEF.md
# Parallel Bus Transaction Phase Tracker

This block sits beside a shared, time-multiplexed parallel bus and drives nothing on it. It watches a frame signal and two ready signals, all active-low, and reports where the current transaction stands. The bus carries an address first and then data. A lane group alongside it carries the bus command during the address phase and active-low byte enables during the data phases.

For each transaction the tracker gives one address strobe, with the captured address and command. It then gives one data strobe for every data phase that completes. Each data strobe comes with the byte enables for that phase, and the final phase also raises a last flag. A wide-transfer flag records whether the initiator asked for the full bus width. A configuration-hit flag records whether the high-active chip select was asserted together with a configuration command. All outputs are registered: each one reflects the clock edge just before it.

Top module: `bus_phase_tracker`

## Requirements
- R1: While reset is high and on the first cycle after it, all strobes and flags are 0, `phase` is 0 (idle), and `addr_o`, `cmd_o` and `be_o` are 0.
- R2: When `phase` is idle, an edge that sees `txn_frame_n` low after a high sample on the previous edge is an address phase. On the next cycle `addr_stb` is 1 for one cycle, `phase` is 1, `addr_o` holds the bus and `cmd_o` holds `lane_cbe_n[3:0]`.
- R3: An edge where either ready is high (a wait state) produces no data strobe. `phase` then reads 2 (data).
- R4: A data phase completes only on an edge where `init_rdy_n` and `tgt_rdy_n` are both low. On the next cycle `data_stb` is 1 and `be_o[i]` is the inverse of `lane_cbe_n[i]`.
- R5: If `wide_req_n` was high at the address phase, `wide_o` is 0 and `be_o[7:4]` reads 0 for every data phase of that transaction.
- R6: If `wide_req_n` was low at the address phase, `wide_o` is 1 and all eight byte enables are reported.
- R7: A completed data phase with `txn_frame_n` high is the final one. `last_stb` is 1 together with `data_stb`, and `phase` returns to 0 in that same cycle.
- R8: `cfg_hit_o` is 1 only if `cfg_sel` was high at the address phase and the command was 4'hA or 4'hB. The value of `cfg_sel` during data phases is ignored.
- R9: `addr_o` and `cmd_o` hold their values through the data phases of a transaction, whatever the bus and lane values are. While frame stays low during data, no new address strobe is given.
- R10: An address phase on the edge right after a final data phase starts a new transaction (back-to-back).
- R11: `wide_o` and `cfg_hit_o` stay valid until the transaction ends. Both clear on the first idle edge after the transaction ends that carries no new address.
- R12: Both readies low while `phase` is idle produce no data strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mux_bus | input | 64 | Multiplexed address/data bus |
| lane_cbe_n | input | 8 | Command (address phase) or active-low byte enables (data) |
| txn_frame_n | input | 1 | Transaction frame, active low |
| init_rdy_n | input | 1 | Initiator ready, active low |
| tgt_rdy_n | input | 1 | Target ready, active low |
| cfg_sel | input | 1 | Configuration chip select, active high |
| wide_req_n | input | 1 | Full-width transfer request, active low |
| addr_stb | output | 1 | One-cycle pulse after an address phase |
| data_stb | output | 1 | One-cycle pulse after a completed data phase |
| last_stb | output | 1 | Pulse marking the final data phase |
| phase | output | 2 | 0 idle, 1 address, 2 data |
| addr_o | output | 64 | Captured address |
| cmd_o | output | 4 | Captured bus command |
| be_o | output | 8 | Active-high byte enables of the last completed phase |
| wide_o | output | 1 | Transaction uses the full width |
| cfg_hit_o | output | 1 | Configuration access selected this device |

## Verification
The bench holds frame low through a burst and checks that no second address strobe appears. A tracker that acted on a low level instead of the falling edge would report a new address on every data phase. It inserts wait states with one ready high, which a design that checked only one ready would count as transfers. It drives active upper byte-enable lanes on a narrow transaction, which a missing width mask would report. It also starts a new address on the edge right after a final phase, which a design that waited an extra idle cycle would miss, and it toggles the chip select during data phases to expose a flag that is not held from the address phase.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_CFG_RD = 4'hA;
  localparam logic [CMD_W-1:0] CMD_CFG_WR = 4'hB;

  function automatic logic is_cfg_cmd(input logic [CMD_W-1:0] c);
    return (c == CMD_CFG_RD) || (c == CMD_CFG_WR);
  endfunction
endpackage

// File: rtl/bpt_phase_fsm.sv
module bpt_phase_fsm
  import bpt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   frame_n,
  input  logic   irdy_n,
  input  logic   trdy_n,
  output phase_e state_o,
  output logic   addr_evt_o,
  output logic   xfer_evt_o,
  output logic   final_evt_o
);
  phase_e state_q, state_d;
  logic   frame_prev_q;

  // address edge: frame seen low while the previous sample was high
  assign addr_evt_o  = (state_q == PH_IDLE) && !frame_n && frame_prev_q;
  assign xfer_evt_o  = (state_q != PH_IDLE) && !irdy_n && !trdy_n;
  assign final_evt_o = xfer_evt_o && frame_n;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: if (addr_evt_o) state_d = PH_ADDR;
      PH_ADDR, PH_DATA: begin
        if (final_evt_o) state_d = PH_IDLE;
        else             state_d = PH_DATA;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= PH_IDLE;
      frame_prev_q <= 1'b1;
    end else begin
      state_q      <= state_d;
      frame_prev_q <= frame_n;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/bpt_addr_latch.sv
module bpt_addr_latch
  import bpt_pkg::*;
#(
  parameter int BUS_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_evt,
  input  logic             idle_now,
  input  logic [BUS_W-1:0] bus,
  input  logic [CMD_W-1:0] cmd_lanes,
  input  logic             sel,
  input  logic             wide_n,
  output logic [BUS_W-1:0] addr_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             wide_o,
  output logic             cfg_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      cmd_o  <= '0;
      wide_o <= 1'b0;
      cfg_o  <= 1'b0;
    end else if (addr_evt) begin
      addr_o <= bus;
      cmd_o  <= cmd_lanes;
      wide_o <= !wide_n;
      cfg_o  <= sel && is_cfg_cmd(cmd_lanes);
    end else if (idle_now) begin
      wide_o <= 1'b0;
      cfg_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/bpt_lane_enables.sv
module bpt_lane_enables #(
  parameter int LANES    = 8,
  parameter int LO_LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_evt,
  input  logic             wide,
  input  logic [LANES-1:0] cbe_n,
  output logic [LANES-1:0] be_o
);
  logic [LANES-1:0] be_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g < LO_LANES) begin : g_low
      assign be_d[g] = !cbe_n[g];
    end else begin : g_high
      assign be_d[g] = !cbe_n[g] && wide;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           be_o <= '0;
    else if (xfer_evt) be_o <= be_d;
  end
endmodule

// File: rtl/bus_phase_tracker.sv
module bus_phase_tracker
  import bpt_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int LO_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [8*LANES-1:0]   mux_bus,
  input  logic [LANES-1:0]     lane_cbe_n,
  input  logic                 txn_frame_n,
  input  logic                 init_rdy_n,
  input  logic                 tgt_rdy_n,
  input  logic                 cfg_sel,
  input  logic                 wide_req_n,
  output logic                 addr_stb,
  output logic                 data_stb,
  output logic                 last_stb,
  output logic [1:0]           phase,
  output logic [8*LANES-1:0]   addr_o,
  output logic [CMD_W-1:0]     cmd_o,
  output logic [LANES-1:0]     be_o,
  output logic                 wide_o,
  output logic                 cfg_hit_o
);
  localparam int BUS_W = 8 * LANES;

  phase_e st;
  logic   addr_evt, xfer_evt, final_evt;

  bpt_phase_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .frame_n     (txn_frame_n),
    .irdy_n      (init_rdy_n),
    .trdy_n      (tgt_rdy_n),
    .state_o     (st),
    .addr_evt_o  (addr_evt),
    .xfer_evt_o  (xfer_evt),
    .final_evt_o (final_evt)
  );

  bpt_addr_latch #(.BUS_W(BUS_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .addr_evt  (addr_evt),
    .idle_now  ((st == PH_IDLE) && !addr_evt),
    .bus       (mux_bus),
    .cmd_lanes (lane_cbe_n[CMD_W-1:0]),
    .sel       (cfg_sel),
    .wide_n    (wide_req_n),
    .addr_o    (addr_o),
    .cmd_o     (cmd_o),
    .wide_o    (wide_o),
    .cfg_o     (cfg_hit_o)
  );

  bpt_lane_enables #(.LANES(LANES), .LO_LANES(LO_LANES)) u_lanes (
    .clk      (clk),
    .rst      (rst),
    .xfer_evt (xfer_evt),
    .wide     (wide_o),
    .cbe_n    (lane_cbe_n),
    .be_o     (be_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_stb <= 1'b0;
      data_stb <= 1'b0;
      last_stb <= 1'b0;
    end else begin
      addr_stb <= addr_evt;
      data_stb <= xfer_evt;
      last_stb <= final_evt;
    end
  end

  assign phase = st;
endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
  parameter int LANES    = 8,
  parameter int LO_LANES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               txn_frame_n,
  input logic               init_rdy_n,
  input logic               tgt_rdy_n,
  input logic               addr_stb,
  input logic               data_stb,
  input logic               last_stb,
  input logic [1:0]         phase,
  input logic [8*LANES-1:0] addr_o,
  input logic [LANES-1:0]   be_o,
  input logic               wide_o
);
  p_addr_stb_phase_r2: assert property (@(posedge clk) disable iff (rst)
    addr_stb |-> (phase == 2'd1 && !data_stb));

  p_data_handshake_r4: assert property (@(posedge clk) disable iff (rst)
    data_stb |-> $past(!init_rdy_n && !tgt_rdy_n));

  p_wait_no_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    (phase != 2'd0 && (init_rdy_n || tgt_rdy_n)) |=> !data_stb);

  p_upper_masked_r5: assert property (@(posedge clk) disable iff (rst)
    (data_stb && !wide_o) |-> (be_o[LANES-1:LO_LANES] == '0));

  p_last_idle_r7: assert property (@(posedge clk) disable iff (rst)
    last_stb |-> (data_stb && phase == 2'd0 && $past(txn_frame_n)));

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && $past(phase) != 2'd0) |-> $stable(addr_o));

  p_idle_no_data_r12: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0) |=> !(data_stb && !last_stb));
endmodule

bind bus_phase_tracker bpt_checker #(.LANES(LANES), .LO_LANES(LO_LANES)) u_bpt_chk (
  .clk         (clk),
  .rst         (rst),
  .txn_frame_n (txn_frame_n),
  .init_rdy_n  (init_rdy_n),
  .tgt_rdy_n   (tgt_rdy_n),
  .addr_stb    (addr_stb),
  .data_stb    (data_stb),
  .last_stb    (last_stb),
  .phase       (phase),
  .addr_o      (addr_o),
  .be_o        (be_o),
  .wide_o      (wide_o)
);

// File: tb/test_bus_phase_tracker.sv
module test_bus_phase_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] mux_bus = '0;
  logic [7:0]  lane_cbe_n = 8'hFF;
  logic        txn_frame_n = 1'b1, init_rdy_n = 1'b1, tgt_rdy_n = 1'b1;
  logic        cfg_sel = 1'b0, wide_req_n = 1'b1;
  logic        addr_stb, data_stb, last_stb, wide_o, cfg_hit_o;
  logic [1:0]  phase;
  logic [63:0] addr_o;
  logic [3:0]  cmd_o;
  logic [7:0]  be_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bus_phase_tracker i_bus_phase_tracker (
    .clk(clk), .rst(rst), .mux_bus(mux_bus), .lane_cbe_n(lane_cbe_n),
    .txn_frame_n(txn_frame_n), .init_rdy_n(init_rdy_n), .tgt_rdy_n(tgt_rdy_n),
    .cfg_sel(cfg_sel), .wide_req_n(wide_req_n), .addr_stb(addr_stb),
    .data_stb(data_stb), .last_stb(last_stb), .phase(phase), .addr_o(addr_o),
    .cmd_o(cmd_o), .be_o(be_o), .wide_o(wide_o), .cfg_hit_o(cfg_hit_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply one bus cycle, let the edge sample it, return just after the edge
  task automatic step(input logic fr, input logic ir, input logic tr,
                      input logic [63:0] ad, input logic [7:0] cbe,
                      input logic sel, input logic w64);
    txn_frame_n = fr; init_rdy_n = ir; tgt_rdy_n = tr;
    mux_bus = ad; lane_cbe_n = cbe; cfg_sel = sel; wide_req_n = w64;
    @(posedge clk); #1;
  endtask

  task automatic idle_cycle();
    step(1, 1, 1, 64'h0, 8'hFF, 0, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    chk("R1 addr_stb", addr_stb, 0);
    chk("R1 data_stb", data_stb, 0);
    chk("R1 phase", phase, 0);
    chk("R1 addr_o", addr_o, 0);
    chk("R1 be_o", be_o, 0);
    chk("R1 flags", {wide_o, cfg_hit_o, last_stb, cmd_o}, 0);
  endtask

  task automatic t_idle_ready();
    step(1, 0, 0, 64'h55, 8'h00, 0, 1);
    chk("R12 no data strobe in idle", data_stb, 0);
    chk("R12 phase stays idle", phase, 0);
    idle_cycle();
  endtask

  task automatic t_narrow_single();
    step(0, 1, 1, 64'hDEAD_0000_1000_0040, 8'h06, 0, 1);
    chk("R2 addr_stb", addr_stb, 1);
    chk("R2 phase addr", phase, 1);
    chk("R2 addr_o", addr_o, 64'hDEAD_0000_1000_0040);
    chk("R2 cmd_o", cmd_o, 4'h6);
    chk("R5 wide_o narrow", wide_o, 0);
    step(1, 0, 1, 64'h1111, 8'h0C, 0, 1);
    chk("R3 wait no data_stb", data_stb, 0);
    chk("R3 phase data", phase, 2);
    chk("R9 addr held", addr_o, 64'hDEAD_0000_1000_0040);
    step(1, 0, 0, 64'h2222, 8'h0C, 0, 1);
    chk("R4 data_stb", data_stb, 1);
    chk("R5 be upper masked", be_o, 8'h03);
    chk("R7 last_stb", last_stb, 1);
    chk("R7 phase idle", phase, 0);
    idle_cycle();
    chk("R7 strobes drop", {addr_stb, data_stb, last_stb}, 0);
  endtask

  task automatic t_wide_burst();
    step(0, 1, 1, 64'hABCD_0000_1234_5678, 8'h07, 0, 0);
    chk("R6 wide_o", wide_o, 1);
    step(0, 0, 0, 64'h0, 8'h00, 0, 1);
    chk("R4 phase 1 strobe", data_stb, 1);
    chk("R6 all lanes", be_o, 8'hFF);
    chk("R9 no new addr_stb", addr_stb, 0);
    chk("R7 not last", last_stb, 0);
    step(0, 1, 0, 64'h9, 8'hAA, 0, 1);
    chk("R3 initiator wait", data_stb, 0);
    step(0, 0, 1, 64'h9, 8'hAA, 0, 1);
    chk("R3 target wait", data_stb, 0);
    chk("R6 be held across waits", be_o, 8'hFF);
    step(1, 0, 0, 64'h1, 8'hF0, 0, 1);
    chk("R4 final strobe", data_stb, 1);
    chk("R6 upper lanes", be_o, 8'h0F);
    chk("R7 last", last_stb, 1);
    chk("R11 wide held at end", wide_o, 1);
    chk("R9 cmd held", cmd_o, 4'h7);
    idle_cycle();
    chk("R11 wide cleared", wide_o, 0);
  endtask

  task automatic t_config();
    step(0, 1, 1, 64'h0000_0000_0000_0104, 8'h0A, 1, 1);
    chk("R8 cfg hit read", cfg_hit_o, 1);
    step(1, 0, 0, 64'h0, 8'h00, 0, 1);
    chk("R8 hit held, sel ignored", cfg_hit_o, 1);
    idle_cycle();
    chk("R11 cfg cleared", cfg_hit_o, 0);
    step(0, 1, 1, 64'h108, 8'h0B, 0, 1);
    chk("R8 sel low no hit", cfg_hit_o, 0);
    step(1, 0, 0, 64'h0, 8'h00, 1, 1);
    chk("R8 data-phase sel ignored", cfg_hit_o, 0);
    idle_cycle();
    step(0, 1, 1, 64'h10C, 8'h06, 1, 1);
    chk("R8 non-config command", cfg_hit_o, 0);
    step(1, 0, 0, 64'h0, 8'h00, 1, 1);
    idle_cycle();
  endtask

  task automatic t_back_to_back();
    step(0, 1, 1, 64'h2000, 8'h0A, 1, 0);
    step(1, 0, 0, 64'h0, 8'hFE, 0, 1);
    chk("R10 first final", last_stb, 1);
    step(0, 1, 1, 64'h3000, 8'h07, 0, 1);
    chk("R10 second addr_stb", addr_stb, 1);
    chk("R10 second addr", addr_o, 64'h3000);
    chk("R10 new flags", {wide_o, cfg_hit_o}, 2'b00);
    chk("R10 phase addr", phase, 1);
    step(1, 0, 0, 64'h0, 8'hF7, 0, 1);
    chk("R5 narrow lanes", be_o, 8'h08);
    idle_cycle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    idle_cycle();
    t_idle_ready();
    t_narrow_single();
    t_wide_burst();
    t_config();
    t_back_to_back();
    repeat (2) idle_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule